// File: doc/BRIEF.md
# Linked Multi-Channel Delay Sequencer

This block runs one timing cycle per start pulse. When a cycle opens, four delay outputs (channels 0 to 3, in the roles A, B, C and D) each rise once their own programmed delay has elapsed. Delays are counted in clock ticks. Every channel picks its reference: either the cycle start or the resolved edge time of another channel. Chained channels therefore move together when an upstream delay is reprogrammed. Once risen, a channel stays high. All channels then drop together a fixed number of hold ticks after the latest edge, and the block is ready for the next cycle.

Two pulse outputs are formed from channel pairs (0,1) and (2,3). Each is high between the earlier and the later edge of its pair. Each has an inverted twin with the same timing. A busy flag spans the whole cycle.

Programming uses a one-cycle write port that loads a channel's delay and reference code together. Reference chains are resolved at the start of each cycle. If the references contain a loop, the cycle is refused and a configuration error flag is raised.

Top module: `dly_seq_top`

## Requirements
- R1: After reset all channel outputs, both pulse outputs, busy and config_error are low; the inverted pulse outputs are high; every delay register is 0 and every reference code is 0.
- R2: A channel referenced to the start (code 0) rises exactly D ticks after busy rises, where D is its delay (D=0 rises with busy). After rising it stays high until the collective fall.
- R3: Reference code k in 1..4 selects channel k-1 as the base. The effective delay is the channel's own delay plus the base's effective delay, applied transitively. Codes 5 to 7 act as code 0.
- R4: All channels fall together HOLD_TICKS ticks after the largest effective delay is reached. Busy is therefore high for exactly max_delay + HOLD_TICKS cycles.
- R5: pulse_ab is high exactly while one of channels 0 and 1 is high and the other is not. pulse_cd does the same for channels 2 and 3. With equal effective delays in a pair, that pulse stays low for the whole cycle.
- R6: pulse_ab_n and pulse_cd_n are the logical inverse of pulse_ab and pulse_cd in every cycle.
- R7: A start while idle with any reference loop (including self-reference) sets config_error, and busy stays low. A start with a loop-free configuration clears config_error and opens a cycle. config_error is never high while busy is high.
- R8: Writes during a cycle do not change that cycle's timing; they apply from the next start. A start while busy is ignored.
- R9: busy rises in the cycle after an accepted start and stays high until the collective fall; while busy is low, all channel and pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Cycle start request, sampled each edge |
| wr_en | input | 1 | Write strobe for the channel registers |
| wr_sel | input | 2 | Channel index written (0..3) |
| wr_ref | input | 3 | Reference code: 0 start, 1..4 channel 0..3, 5..7 start |
| wr_delay | input | TW (48) | Delay in ticks for the selected channel |
| ch_out | output | 4 | Delay channel outputs, bit i is channel i |
| pulse_ab | output | 1 | Pulse between channel 0 and 1 edges |
| pulse_ab_n | output | 1 | Inverse of pulse_ab |
| pulse_cd | output | 1 | Pulse between channel 2 and 3 edges |
| pulse_cd_n | output | 1 | Inverse of pulse_cd |
| busy | output | 1 | Timing cycle in progress |
| config_error | output | 1 | Last start attempt found a reference loop |

## Verification
The properties assume that reset is held for at least one edge and that HOLD_TICKS is at least one, so every cycle has a collective fall that follows the last rise. They also assume that wr_sel only names existing channels. The stimulus drives every input on the falling clock edge and keeps delays small, so many full cycles fit in the run. It deliberately issues writes and extra start pulses inside busy cycles, and it programs both two-channel and self-referencing loops, so the refusal path and the unaffected-cycle paths are both exercised against the bench's behavioural model.

// File: rtl/dly_seq_pkg.sv
// Package: shared constants and reference-code helpers for the delay sequencer.
// Assumes four channels; reference code 0 means the cycle start, 1..NUM_CH
// select a channel, anything above NUM_CH also means the cycle start.
package dly_seq_pkg;
    localparam int NUM_CH = 4;
    localparam int CH_IW  = $clog2(NUM_CH);
    localparam int REF_W  = $clog2(NUM_CH + 1);
    localparam int PAIRS  = NUM_CH / 2;

    // True when a reference code points at the cycle start.
    function automatic logic ref_is_start(input logic [REF_W-1:0] code);
        return (code == '0) || (int'(code) > NUM_CH);
    endfunction

    // Channel index selected by a non-start reference code.
    function automatic logic [CH_IW-1:0] ref_chan(input logic [REF_W-1:0] code);
        return CH_IW'(code - REF_W'(1));
    endfunction
endpackage

// File: rtl/dly_cfg_bank.sv
// Module: per-channel delay and reference registers.
// Loads one channel per write strobe; values persist until rewritten or reset.
// Assumes wr_sel names an existing channel.
module dly_cfg_bank
    import dly_seq_pkg::*;
#(
    parameter int TW = 48
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [CH_IW-1:0]               wr_sel,
    input  logic [REF_W-1:0]               wr_ref,
    input  logic [TW-1:0]                  wr_delay,
    output logic [NUM_CH-1:0][TW-1:0]      dly_o,
    output logic [NUM_CH-1:0][REF_W-1:0]   ref_o
);
    // Store delay and reference code for the addressed channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_o <= '0;
            ref_o <= '0;
        end else if (wr_en) begin
            dly_o[wr_sel] <= wr_delay;
            ref_o[wr_sel] <= wr_ref;
        end
    end
endmodule

// File: rtl/dly_ref_resolver.sv
// Module: resolves each channel's effective delay by following its reference
// chain, and flags any chain that never reaches the cycle start.
// Purely combinational; a loop-free chain has at most NUM_CH-1 hops.
module dly_ref_resolver
    import dly_seq_pkg::*;
#(
    parameter int TW = 48,
    parameter int EW = TW + CH_IW
) (
    input  logic [NUM_CH-1:0][TW-1:0]    dly_i,
    input  logic [NUM_CH-1:0][REF_W-1:0] ref_i,
    output logic [NUM_CH-1:0][EW-1:0]    eff_o,
    output logic                         loop_o
);
    logic [NUM_CH-1:0] loop_vec;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_walk
        logic [CH_IW-1:0] node;
        logic [EW-1:0]    acc;
        // Follow the chain hop by hop, adding each base channel's own delay.
        always_comb begin
            node = CH_IW'(g);
            acc  = EW'(dly_i[g]);
            for (int h = 0; h < NUM_CH - 1; h++) begin
                if (!ref_is_start(ref_i[node])) begin
                    node = ref_chan(ref_i[node]);
                    acc  = acc + EW'(dly_i[node]);
                end
            end
            eff_o[g]    = acc;
            loop_vec[g] = !ref_is_start(ref_i[node]);
        end
    end

    assign loop_o = |loop_vec;
endmodule

// File: rtl/dly_cycle_ctrl.sv
// Module: timing-cycle controller. On an accepted start it latches the resolved
// delays, then counts ticks until the hold window after the latest edge expires.
// Assumes HOLD_TICKS >= 1. Starts while busy are ignored.
module dly_cycle_ctrl
    import dly_seq_pkg::*;
#(
    parameter int EW         = 50,
    parameter int CW         = EW + 1,
    parameter int HOLD_TICKS = 200
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      loop_i,
    input  logic [NUM_CH-1:0][EW-1:0] eff_i,
    output logic                      busy_o,
    output logic [CW-1:0]             tick_o,
    output logic [NUM_CH-1:0][EW-1:0] eff_q_o,
    output logic                      cfg_err_o
);
    logic [EW-1:0] span;
    logic [CW-1:0] last_c;
    logic [CW-1:0] last_q;

    // Largest effective delay decides where the hold window begins.
    always_comb begin
        span = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (eff_i[k] > span) span = eff_i[k];
        end
        last_c = CW'(span) + CW'(HOLD_TICKS - 1);
    end

    // Cycle state: accept start, count ticks, end after the hold window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o    <= 1'b0;
            tick_o    <= '0;
            eff_q_o   <= '0;
            last_q    <= '0;
            cfg_err_o <= 1'b0;
        end else if (busy_o) begin
            if (tick_o == last_q) begin
                busy_o <= 1'b0;
                tick_o <= '0;
            end else begin
                tick_o <= tick_o + CW'(1);
            end
        end else if (start_i) begin
            if (loop_i) begin
                cfg_err_o <= 1'b1;
            end else begin
                cfg_err_o <= 1'b0;
                busy_o    <= 1'b1;
                tick_o    <= '0;
                eff_q_o   <= eff_i;
                last_q    <= last_c;
            end
        end
    end
endmodule

// File: rtl/dly_seq_top.sv
// Module: linked four-channel delay sequencer top. Ties the register bank,
// reference resolver and cycle controller together and forms the channel,
// pair-pulse and inverted pulse outputs from the latched cycle state.
// Assumes synchronous active-low reset and HOLD_TICKS >= 1.
module dly_seq_top
    import dly_seq_pkg::*;
#(
    parameter int TW         = 48,
    parameter int HOLD_TICKS = 200
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 wr_en,
    input  logic [CH_IW-1:0]     wr_sel,
    input  logic [REF_W-1:0]     wr_ref,
    input  logic [TW-1:0]        wr_delay,
    output logic [NUM_CH-1:0]    ch_out,
    output logic                 pulse_ab,
    output logic                 pulse_ab_n,
    output logic                 pulse_cd,
    output logic                 pulse_cd_n,
    output logic                 busy,
    output logic                 config_error
);
    localparam int EW = TW + CH_IW;
    localparam int CW = EW + 1;

    logic [NUM_CH-1:0][TW-1:0]    dly;
    logic [NUM_CH-1:0][REF_W-1:0] refs;
    logic [NUM_CH-1:0][EW-1:0]    eff;
    logic [NUM_CH-1:0][EW-1:0]    eff_q;
    logic                         loop_found;
    logic [CW-1:0]                tick;
    logic [PAIRS-1:0]             pair_pulse;

    dly_cfg_bank #(.TW(TW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_ref   (wr_ref),
        .wr_delay (wr_delay),
        .dly_o    (dly),
        .ref_o    (refs)
    );

    dly_ref_resolver #(.TW(TW), .EW(EW)) u_resolve (
        .dly_i  (dly),
        .ref_i  (refs),
        .eff_o  (eff),
        .loop_o (loop_found)
    );

    dly_cycle_ctrl #(.EW(EW), .CW(CW), .HOLD_TICKS(HOLD_TICKS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .loop_i    (loop_found),
        .eff_i     (eff),
        .busy_o    (busy),
        .tick_o    (tick),
        .eff_q_o   (eff_q),
        .cfg_err_o (config_error)
    );

    // Each channel is high once the tick count reaches its latched delay.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        assign ch_out[g] = busy & (tick >= CW'(eff_q[g]));
    end

    // A pair pulse spans the gap between its two channel edges.
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        assign pair_pulse[p] = ch_out[2*p] ^ ch_out[2*p+1];
    end

    assign pulse_ab   = pair_pulse[0];
    assign pulse_cd   = pair_pulse[1];
    assign pulse_ab_n = ~pair_pulse[0];
    assign pulse_cd_n = ~pair_pulse[1];
endmodule

// File: rtl/dly_seq_checks.sv
// Module: property checker for the delay sequencer, attached by bind.
// Observes ports only; assumes reset is asserted before the first edge.
module dly_seq_checks
    import dly_seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] ch_out,
    input logic              pulse_ab,
    input logic              pulse_ab_n,
    input logic              pulse_cd,
    input logic              pulse_cd_n,
    input logic              busy,
    input logic              config_error
);
    // R9: nothing is driven high outside a cycle.
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ch_out == '0) && !pulse_ab && !pulse_cd);

    // R2: a risen channel holds until the cycle ends.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_hold
        a_r2_stays_high: assert property (@(posedge clk) disable iff (!rst_n)
            (busy && ch_out[g]) |=> (ch_out[g] || !busy));
    end

    // R4: the cycle only ends after every channel has risen.
    a_r4_all_high_before_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (&$past(ch_out)));

    // R7: a refused configuration never coexists with a running cycle.
    a_r7_err_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        config_error |-> !busy);

    // R6: inverted pulse outputs always oppose their true outputs.
    a_r6_ab_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_ab_n != pulse_ab);
    a_r6_cd_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_cd_n != pulse_cd);

    // R5: a pair pulse implies its two channels disagree.
    a_r5_ab_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_ab |-> (ch_out[0] != ch_out[1]));
endmodule

bind dly_seq_top dly_seq_checks u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .ch_out       (ch_out),
    .pulse_ab     (pulse_ab),
    .pulse_ab_n   (pulse_ab_n),
    .pulse_cd     (pulse_cd),
    .pulse_cd_n   (pulse_cd_n),
    .busy         (busy),
    .config_error (config_error)
);

// File: tb/dly_seq_top_bench.sv
module dly_seq_top_bench;
    localparam int TW   = 48;
    localparam int HOLD = 200;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [2:0]    wr_ref = '0;
    logic [TW-1:0] wr_delay = '0;
    logic [3:0]    ch_out;
    logic          pulse_ab, pulse_ab_n, pulse_cd, pulse_cd_n, busy, config_error;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int cyc = 0;

    // Behavioural reference model state.
    longint m_dly[4];
    int     m_ref[4];
    longint m_eff[4];
    longint m_tick = 0;
    longint m_last = 0;
    bit     m_busy = 0;
    bit     m_err = 0;

    always #2 clk = ~clk;

    dly_seq_top #(.TW(TW), .HOLD_TICKS(HOLD)) u_dly_seq_top (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_ref(wr_ref), .wr_delay(wr_delay), .ch_out(ch_out),
        .pulse_ab(pulse_ab), .pulse_ab_n(pulse_ab_n), .pulse_cd(pulse_cd),
        .pulse_cd_n(pulse_cd_n), .busy(busy), .config_error(config_error)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Walk a reference chain; returns 1 when it ends at the start.
    function automatic bit m_walk(input int c, output longint e);
        int node = c;
        e = m_dly[c];
        for (int s = 0; s <= 4; s++) begin
            if (m_ref[node] < 1 || m_ref[node] > 4) return 1'b1;
            node = m_ref[node] - 1;
            e += m_dly[node];
        end
        return 1'b0;
    endfunction

    // Model update on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 4; c++) begin m_dly[c] = 0; m_ref[c] = 0; m_eff[c] = 0; end
            m_busy = 0; m_err = 0; m_tick = 0; m_last = 0;
        end else begin
            if (m_busy) begin
                if (m_tick == m_last) begin m_busy = 0; m_tick = 0; end
                else m_tick++;
            end else if (start) begin
                bit ok;
                longint e[4];
                longint mx;
                ok = 1;
                mx = 0;
                for (int c = 0; c < 4; c++) ok &= m_walk(c, e[c]);
                if (!ok) m_err = 1;
                else begin
                    m_err = 0; m_busy = 1; m_tick = 0;
                    for (int c = 0; c < 4; c++) begin
                        m_eff[c] = e[c];
                        if (e[c] > mx) mx = e[c];
                    end
                    m_last = mx + HOLD - 1;
                end
            end
            if (wr_en) begin
                m_dly[wr_sel] = longint'(wr_delay);
                m_ref[wr_sel] = int'(wr_ref);
            end
        end
    end

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit ec[4];
            for (int c = 0; c < 4; c++) begin
                ec[c] = m_busy && (m_tick >= m_eff[c]);
                chk(ch_out[c] == ec[c], $sformatf("R2/R3 ch%0d", c), ch_out[c], ec[c]);
            end
            chk(pulse_ab == (ec[0] ^ ec[1]), "R5 pulse_ab", pulse_ab, ec[0] ^ ec[1]);
            chk(pulse_cd == (ec[2] ^ ec[3]), "R5 pulse_cd", pulse_cd, ec[2] ^ ec[3]);
            chk(pulse_ab_n == !(ec[0] ^ ec[1]), "R6 pulse_ab_n", pulse_ab_n, !(ec[0] ^ ec[1]));
            chk(pulse_cd_n == !(ec[2] ^ ec[3]), "R6 pulse_cd_n", pulse_cd_n, !(ec[2] ^ ec[3]));
            chk(busy == m_busy, "R9 busy", busy, m_busy);
            chk(config_error == m_err, "R7 config_error", config_error, m_err);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            finish_up();
        end
    end

    task automatic wr(input int sel, input int rcode, input longint d);
        @(negedge clk);
        wr_en = 1; wr_sel = 2'(sel); wr_ref = 3'(rcode); wr_delay = TW'(d);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic kick();
        @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wait_rise(input int c, input int exp, input string tag);
        int n = 0;
        while (!ch_out[c] && n < 5000) begin @(negedge clk); n++; end
        chk(n == exp, tag, n, exp);
    endtask

    task automatic busy_len(input int exp, input string tag);
        int n = 0;
        while (busy && n < 5000) begin @(negedge clk); n++; end
        chk(n == exp, tag, n, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state at the ports.
        chk(ch_out == 4'b0, "R1 ch_out", ch_out, 0);
        chk(!busy && !config_error, "R1 busy/err", {busy, config_error}, 0);
        chk(!pulse_ab && !pulse_cd && pulse_ab_n && pulse_cd_n, "R1 pulses",
            {pulse_ab, pulse_cd, pulse_ab_n, pulse_cd_n}, 3);

        // R1: all-zero delays rise with busy.
        kick();
        chk(ch_out == 4'hF, "R1 zero delays rise at once", ch_out, 15);
        busy_len(HOLD, "R4 busy length with zero delays");
        wait_idle();

        // R2 and R5: start-referenced delays, equal C and D keep pulse_cd low.
        wr(0, 0, 3); wr(1, 0, 7); wr(2, 0, 10); wr(3, 0, 10);
        kick();
        wait_rise(0, 3, "R2 ch0 rise tick");
        busy_len(10 + HOLD - 3, "R4 remaining busy after ch0");
        wait_idle();

        // R3: chained references 0<-start, 1<-0, 2<-1, 3<-start; code 6 acts as start.
        wr(0, 0, 5); wr(1, 1, 4); wr(2, 2, 2); wr(3, 6, 1);
        kick();
        wait_rise(2, 11, "R3 chained ch2 rise tick");
        wait_idle();

        // R8: rewrite ch0 mid-cycle; current cycle keeps ch1 at 9, next moves it to 24.
        kick();
        wr(0, 0, 20);
        wait_rise(1, 7, "R8 ch1 unaffected by write during cycle");
        kick();
        chk(busy == 1, "R8 start while busy ignored, still busy", busy, 1);
        wait_idle();
        kick();
        wait_rise(1, 24, "R8 ch1 follows new base delay");
        wait_idle();

        // R5: reversed pair order (ch1 earlier than ch0).
        wr(0, 0, 12); wr(1, 0, 4); wr(2, 4, 3); wr(3, 0, 6);
        kick();
        busy_len(12 + HOLD, "R4 busy spans max delay plus hold");
        wait_idle();

        // R7: two-channel loop refused, then self loop, then recovery.
        wr(0, 2, 1); wr(1, 1, 1);
        kick();
        chk(config_error && !busy, "R7 loop refused", {config_error, busy}, 2);
        repeat (5) @(negedge clk);
        chk(ch_out == 0, "R7 no outputs after refusal", ch_out, 0);
        wr(0, 0, 2); wr(1, 0, 8); wr(2, 3, 5);
        kick();
        chk(config_error && !busy, "R7 self loop refused", {config_error, busy}, 2);
        wr(2, 2, 5);
        kick();
        chk(!config_error && busy, "R7 clean start clears error", {config_error, busy}, 1);
        wait_rise(2, 13, "R3 ch2 on ch1 base");
        wait_idle();

        repeat (4) @(negedge clk);
        finish_up();
    end
endmodule